// File: doc/BRIEF.md
# Fan Tachometer Speed Meter

This block turns the pulse train from a fan's open-collector tachometer line into a speed reading in revolutions per minute. The tach line is treated as plain data. A chain of flip-flops clocked by the system clock samples it. A rising edge is recognised when the newest synchronized sample is high and the sample one cycle older is low.

Rising edges are counted inside a fixed gate window, which lasts one second at the default 100 MHz system clock. When a window closes, the block scales the count to RPM, places the result on the output and starts the next window at once. A fan that gives two pulses per revolution makes each counted pulse worth 30 RPM. The reading is therefore refreshed once per window, in steps of 30 RPM.

The result leaves the block as a stream with no back-pressure. `rpm_valid` is high for one cycle when a new value appears. `rpm` then stays unchanged until the next strobe, so a consumer may sample it at any time and may ignore the strobe. The block has no ready input and never stalls.

Top module: `fan_tach_meter`

## Requirements
- R1: The tach input reaches the edge detector only through `SYNC_STAGES` flip-flops clocked by `clk`. Each low-to-high transition of the synchronized line counts exactly once, however long the line then stays high.
- R2: Windows last exactly `GATE_CYCLES` clock cycles. The first window starts when reset is released. `rpm_valid` is high for exactly one cycle at the end of every window.
- R3: The value shown with `rpm_valid` is the number of edges counted in the window just closed, multiplied by 60 / `PULSES_PER_REV` (30 RPM per edge by default).
- R4: `rpm` changes only in the cycle in which `rpm_valid` rises. Between updates it holds its value.
- R5: During and after reset, `rpm` is 0 and `rpm_valid` is 0.
- R6: An edge detected in the last cycle of a window is not lost. It is counted in the following window.
- R7: The edge count saturates at 2^`CNT_W`-1 and does not wrap. A window with more edges than that reports (2^`CNT_W`-1) × 60 / `PULSES_PER_REV`.
- R8: A window that contains no rising edge reports 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every flip-flop in the block uses it |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | 1 | Raw tachometer line, asynchronous to `clk` |
| rpm | output | RPM_W | Latest speed reading in RPM; held between updates |
| rpm_valid | output | 1 | One-cycle strobe marking a new `rpm` value |

## Verification
The bench targets an edge that lands in the very last cycle of a window. A design that cleared the counter without carrying that edge forward would report one step too little in the next window. A design that folded the edge into the closing window would report one step too much. A tach high time of hundreds of cycles checks that a level-sensitive counter, which would return far too large a reading, is caught. A burst larger than the count width checks that a wrapping counter, which would report a small value instead of the ceiling, is caught. The bench also measures the spacing between strobes and samples `rpm` in the middle of a window, to catch an off-by-one gate length and an output that follows the running count.

// File: rtl/fan_tach_pkg.sv
`timescale 1ns/1ps
package fan_tach_pkg;

  // Saturating increment used by the edge counter.
  function automatic logic [31:0] sat_step(input logic [31:0] cur,
                                           input logic [31:0] ceiling);
    return (cur >= ceiling) ? ceiling : cur + 32'd1;
  endfunction

  // RPM contributed by one counted tach edge.
  function automatic int rpm_per_edge(input int pulses_per_rev);
    return 60 / pulses_per_rev;
  endfunction

endpackage

// File: rtl/tach_edge_sync.sv
`timescale 1ns/1ps
module tach_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_async,
  output logic rise_pulse
);
  logic [SYNC_STAGES-1:0] stage_q;
  logic                   last_q;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= line_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= 1'b0;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= stage_q[SYNC_STAGES-1];
  end

  assign rise_pulse = stage_q[SYNC_STAGES-1] & ~last_q;

  // R1: a single transition yields a single-cycle pulse
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/gate_timer.sv
`timescale 1ns/1ps
module gate_timer #(
  parameter int GATE_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic window_end
);
  localparam int GW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [GW-1:0] LAST = GW'(GATE_CYCLES - 1);

  logic [GW-1:0] tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tick_q <= '0;
    else if (window_end) tick_q <= '0;
    else                 tick_q <= tick_q + 1'b1;
  end

  assign window_end = (tick_q == LAST);

  // R2: inside a window the timer advances by exactly one per cycle
  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !window_end |=> (tick_q == $past(tick_q) + 1'b1));

  // R2: a window end is followed by a fresh start
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    window_end |=> (tick_q == '0) && !window_end);

endmodule

// File: rtl/edge_tally.sv
`timescale 1ns/1ps
module edge_tally
  import fan_tach_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             restart,
  output logic [CNT_W-1:0] tally
);
  localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] tally_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tally_q <= '0;
    else if (restart)
      tally_q <= hit ? CNT_W'(1) : '0;
    else if (hit)
      tally_q <= CNT_W'(sat_step(32'(tally_q), 32'(CEIL)));
  end

  assign tally = tally_q;

  // R7: once full, the tally stays full until restarted
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tally_q == CEIL && !restart) |=> (tally_q == CEIL));

  // R6: an edge in the restart cycle seeds the next window
  p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && hit) |=> (tally_q == CNT_W'(1)));

endmodule

// File: rtl/fan_tach_meter.sv
`timescale 1ns/1ps
module fan_tach_meter
  import fan_tach_pkg::*;
#(
  parameter int GATE_CYCLES    = 100_000_000,
  parameter int SYNC_STAGES    = 2,
  parameter int PULSES_PER_REV = 2,
  parameter int CNT_W          = 16,
  parameter int RPM_W          = CNT_W + $clog2(60 / PULSES_PER_REV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_in,
  output logic [RPM_W-1:0] rpm,
  output logic             rpm_valid
);
  localparam int STEP = rpm_per_edge(PULSES_PER_REV);

  logic             rise;
  logic             win_end;
  logic [CNT_W-1:0] tally;
  logic [RPM_W-1:0] rpm_q;
  logic             valid_q;

  tach_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_async(tach_in), .rise_pulse(rise));

  gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
    .clk(clk), .rst_n(rst_n), .window_end(win_end));

  edge_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .hit(rise), .restart(win_end), .tally(tally));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpm_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= win_end;
      if (win_end) rpm_q <= RPM_W'(tally) * RPM_W'(STEP);
    end
  end

  assign rpm       = rpm_q;
  assign rpm_valid = valid_q;

  // R4: the reading holds outside the update cycle
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(rpm));

  // R3: a strobed value is the closed window's tally times the step
  p_scale_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (rpm == RPM_W'($past(tally)) * RPM_W'(STEP)) && rpm_valid);

  // R2: the strobe is a single-cycle pulse
  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rpm_valid |=> !rpm_valid);

endmodule

// File: tb/fan_tach_meter_tb.sv
`timescale 1ns/1ps
module fan_tach_meter_tb;
  localparam int G     = 1000;
  localparam int CW    = 5;
  localparam int STEP  = 30;
  localparam int RW    = CW + 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tach = 1'b0;
  logic [RW-1:0] rpm;
  logic          rpm_valid;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  int cyc = 0;
  int last_upd = -1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fan_tach_meter #(.GATE_CYCLES(G), .CNT_W(CW), .RPM_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tach_in(tach), .rpm(rpm), .rpm_valid(rpm_valid));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    tach = 1'b1;
    repeat (hi) @(negedge clk);
    tach = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic wait_update();
    do @(negedge clk); while (!rpm_valid);
  endtask

  always @(posedge clk) if (rst_n) cyc++;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rpm_valid) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected update", 1, 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        check("R3 reading", int'(rpm), e);
      end
      if (last_upd >= 0) check("R2 window length", cyc - last_upd, G);
      else               check("R2 first window", cyc, G);
      last_upd = cyc;
    end
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R5 reset rpm", int'(rpm), 0);
    check("R5 reset valid", int'(rpm_valid), 0);
    rst_n = 1'b1;
    // R8: first window is empty
    exp_q.push_back(0);
    wait_update();
    // R3: five pulses
    exp_q.push_back(5 * STEP);
    repeat (5) pulse(3, 3);
    wait_update();
    // R4: twelve narrow pulses; reading still old mid-window
    exp_q.push_back(12 * STEP);
    repeat (12) pulse(2, 2);
    repeat (200) @(negedge clk);
    check("R4 hold mid-window", int'(rpm), 5 * STEP);
    wait_update();
    // R1: one very long high pulse counts once
    exp_q.push_back(1 * STEP);
    pulse(400, 10);
    wait_update();
    // R8: empty window
    exp_q.push_back(0);
    wait_update();
    // R7: 40 pulses saturate a 5-bit tally
    exp_q.push_back(31 * STEP);
    repeat (40) pulse(2, 3);
    wait_update();
    // R6: edge in the last cycle of the window carries over
    exp_q.push_back(2 * STEP);
    exp_q.push_back(3 * STEP);
    repeat (2) pulse(3, 3);
    repeat (G - 3 - 12) @(negedge clk);
    tach = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 update at boundary", int'(rpm_valid), 1);
    tach = 1'b0;
    repeat (3) @(negedge clk);
    repeat (2) pulse(3, 3);
    wait_update();
    repeat (5) @(negedge clk);
    check("R4 held after update", int'(rpm), 3 * STEP);
    check("R2 strobe single cycle", int'(rpm_valid), 0);
    check("R3 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule